// File: doc/BRIEF.md
# PCIe Port Reset Manager

This block governs the fundamental-reset pin and the reset routing for a set of PCIe controller ports (four by default). Each port can be told to listen to its incoming PERST_L pin, to drive its outgoing PERST_L pin, or both. The block then routes each reset source by policy. A pin assertion can become a chip-wide warm-reset request or only a per-port interrupt. A link-down or hot-reset event can become a warm-reset request, a per-port interrupt, and/or a self-set of the port's soft reset.

Configuration defaults come from a per-port root/endpoint strap and are loaded only by cold reset. A warm reset clears the interrupt flags but keeps every configuration bit. Software reads and writes one configuration word per port and one shared interrupt word through a simple single-cycle register port. The block reports a per-port reset-done status, which is low while the port is being held in reset.

Top module: `perst_rst_ctrl`

## Requirements
- R1: With receive enable 0, the incoming pin has no effect: pin readback is 0, no PERST interrupt is set, no warm request is raised, and reset-done is not lowered by it; the chip-reset control is then ignored as well.
- R2: With receive enable 1 and chip-reset control 1, an asserted (low) incoming pin drives `chip_warm_req` high one clock after the synchronized pin shows assertion, and it stays high while the pin is held.
- R3: With receive enable 1 and chip-reset control 0, an asserted pin sets PERST interrupt flag i (bit i of the interrupt word), and `irq` goes high.
- R4: Reset-done of a port is 0 while its soft-reset bit is 1, or while receive enable is 1 and the synchronized pin is asserted; otherwise it is 1. It appears on `port_rst_done[i]` and at bit 7 of the configuration word.
- R5: A link-down or hot-reset pulse on a port with link-warm enable 1 and reset-done 1 makes `chip_warm_req` high for the next cycle. With link-warm enable 0 it sets link interrupt flag i (bit NPORTS+i of the interrupt word) and raises no warm request. With enable 1 and reset-done 0 it does neither.
- R6: A link-down or hot-reset pulse with soft-reset-on-link enable 1 sets the port's soft-reset bit; this set wins over a register write in the same cycle.
- R7: Cold reset loads each port from its strap. Host (strap 1): drive 1, receive 0, link-warm 0, soft reset 1. Endpoint (strap 0): drive 0, receive 1, link-warm 1, soft reset 0. Chip-reset control and soft-reset-on-link start at 0.
- R8: `perst_oe[i]` equals the drive enable, and `perst_out_n[i]` is low exactly when the port's soft-reset bit is 1.
- R9: A warm reset clears all interrupt flags and leaves every port's configuration bits unchanged.
- R10: Pin readback (bit 6 of the configuration word) is 1 when receive enable is 1 and the synchronized pin is asserted, and 0 when receive enable is 1 and the pin is deasserted.
- R11: Interrupt flags are write-1-to-clear through the interrupt word at address NPORTS, and writing 0 to a bit leaves it. The incoming pin passes two synchronizer flops, so it is seen at readback after the second rising edge and sets a flag on the third.
- R12: Configuration word i sits at address i: bit 0 drive enable, bit 1 receive enable, bit 2 chip-reset control, bit 3 link-warm enable, bit 4 soft-reset-on-link, bit 5 soft reset (all read/write); bit 6 pin readback, bit 7 reset-done, bit 8 strap (read-only). Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous assert |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous assert |
| host_strap | input | NPORTS | Per-port root (1) / endpoint (0) strap |
| perst_in_n | input | NPORTS | Incoming PERST_L pins, active low |
| perst_out_n | output | NPORTS | Outgoing PERST_L values, active low |
| perst_oe | output | NPORTS | Output enable for the outgoing pins |
| link_down | input | NPORTS | Link-down event pulses |
| hot_rst | input | NPORTS | Hot-reset event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on address |
| port_rst_done | output | NPORTS | Per-port reset-done status |
| chip_warm_req | output | 1 | Registered chip warm-reset request |
| irq | output | 1 | OR of all interrupt flags |

## Verification
A corrupted configuration bit shows at once at the configuration-word readback and, for the drive and soft-reset bits, on `perst_oe` and `perst_out_n` in the same cycle. A wrong synchronizer or routing state shows on pin readback and reset-done within two edges of a pin change. It shows on the interrupt word or `chip_warm_req` one edge later. A lost or spurious event pulse is visible on `chip_warm_req` only in the single cycle after the pulse, so the bench samples exactly there, and then reads the sticky interrupt flag and the soft-reset bit, which keep the evidence.

// File: rtl/perst_pkg.sv
package perst_pkg;

  localparam int CFG_W      = 6;
  localparam int PINVAL_BIT = 6;
  localparam int DONE_BIT   = 7;
  localparam int STRAP_BIT  = 8;
  localparam int RD_W       = 9;

  // bit 0 is drv_en, bit 5 is soft_rst
  typedef struct packed {
    logic soft_rst;
    logic soft_on_link;
    logic link_warm_en;
    logic chip_en;
    logic rcv_en;
    logic drv_en;
  } port_cfg_t;

  function automatic port_cfg_t cfg_default(input logic is_host);
    port_cfg_t c;
    c.drv_en       = is_host;
    c.rcv_en       = ~is_host;
    c.chip_en      = 1'b0;
    c.link_warm_en = ~is_host;
    c.soft_on_link = 1'b0;
    c.soft_rst     = is_host;
    return c;
  endfunction

endpackage

// File: rtl/perst_rst_sync.sv
module perst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q, q_d;

  always_comb q_d = {q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  assign srst_n = q[STAGES-1];
endmodule

// File: rtl/perst_in_sync.sv
module perst_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_n_sync
);
  logic [STAGES-1:0] q, q_d;

  always_comb q_d = {q[STAGES-2:0], pin_n};

  // deasserted pin level is 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_d;
  end

  assign pin_n_sync = q[STAGES-1];
endmodule

// File: rtl/perst_port.sv
module perst_port
  import perst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             cfg_rst_n,
  input  logic             irq_rst_n,
  input  logic             host_strap,
  input  logic             perst_in_n,
  input  logic             link_down,
  input  logic             hot_rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             perst_clr,
  input  logic             link_clr,
  output logic [RD_W-1:0]  rd_word,
  output logic             perst_irq,
  output logic             link_irq,
  output logic             warm_req,
  output logic             perst_out_n,
  output logic             perst_oe,
  output logic             rst_done
);
  port_cfg_t cfg_q, cfg_d;
  logic      cfg_en;
  logic      pin_n_s, perst_act, rcv_hit, link_evt;
  logic      perst_set, link_set, perst_irq_d, link_irq_d;

  perst_in_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk        (clk),
    .rst_n      (cfg_rst_n),
    .pin_n      (perst_in_n),
    .pin_n_sync (pin_n_s)
  );

  always_comb begin
    perst_act = ~pin_n_s;
    rcv_hit   = cfg_q.rcv_en & perst_act;
    rst_done  = ~cfg_q.soft_rst & ~rcv_hit;
    link_evt  = link_down | hot_rst;
    warm_req  = (rcv_hit & cfg_q.chip_en)
              | (link_evt & cfg_q.link_warm_en & rst_done);
    perst_set = rcv_hit & ~cfg_q.chip_en;
    link_set  = link_evt & ~cfg_q.link_warm_en;
  end

  // configuration next state: event set of soft_rst wins over a write
  always_comb begin
    cfg_en = cfg_we | (link_evt & cfg_q.soft_on_link);
    cfg_d  = cfg_q;
    if (cfg_we) cfg_d = port_cfg_t'(cfg_wdata);
    if (link_evt && cfg_q.soft_on_link) cfg_d.soft_rst = 1'b1;
  end

  always_ff @(posedge clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n)  cfg_q <= cfg_default(host_strap);
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // interrupt flags: set wins over write-1-to-clear
  always_comb begin
    perst_irq_d = perst_set | (perst_irq & ~perst_clr);
    link_irq_d  = link_set  | (link_irq  & ~link_clr);
  end

  always_ff @(posedge clk or negedge irq_rst_n) begin
    if (!irq_rst_n) begin
      perst_irq <= 1'b0;
      link_irq  <= 1'b0;
    end else begin
      perst_irq <= perst_irq_d;
      link_irq  <= link_irq_d;
    end
  end

  always_comb begin
    perst_oe    = cfg_q.drv_en;
    perst_out_n = ~cfg_q.soft_rst;
    rd_word     = {host_strap, rst_done, rcv_hit, cfg_q};
  end

  // R1
  rcv_off_no_irq_chk: assert property (@(posedge clk) disable iff (!irq_rst_n)
    (!cfg_q.rcv_en && !perst_irq) |=> !perst_irq);

  // R3
  perst_irq_set_chk: assert property (@(posedge clk) disable iff (!irq_rst_n)
    (cfg_q.rcv_en && !cfg_q.chip_en && perst_act) |=> perst_irq);

  // R5
  link_irq_set_chk: assert property (@(posedge clk) disable iff (!irq_rst_n)
    (link_evt && !cfg_q.link_warm_en) |=> link_irq);

  // R6
  soft_on_link_chk: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    (link_evt && cfg_q.soft_on_link) |=> cfg_q.soft_rst);

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!irq_rst_n)
    (perst_clr && !perst_set) |=> !perst_irq);
endmodule

// File: rtl/perst_rst_ctrl.sv
module perst_rst_ctrl
  import perst_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NPORTS + 1),
  localparam int IRQ_W      = 2 * NPORTS,
  localparam int USED_W     = (CFG_W > IRQ_W) ? CFG_W : IRQ_W
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [NPORTS-1:0] host_strap,
  input  logic [NPORTS-1:0] perst_in_n,
  output logic [NPORTS-1:0] perst_out_n,
  output logic [NPORTS-1:0] perst_oe,
  input  logic [NPORTS-1:0] link_down,
  input  logic [NPORTS-1:0] hot_rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NPORTS-1:0] port_rst_done,
  output logic              chip_warm_req,
  output logic              irq
);
  logic              cfg_rst_n, irq_rst_n;
  logic              warm_arst_n;
  logic [NPORTS-1:0] perst_irq, link_irq, warm_vec, cfg_we;
  logic              irq_wr, warm_req_d;
  logic [RD_W-1:0]   rd_words [NPORTS];
  logic              wdata_unused;

  assign warm_arst_n  = cold_rst_n & warm_rst_n;
  assign wdata_unused = ^reg_wdata[DATA_W-1:USED_W];

  perst_rst_sync #(.STAGES(2)) u_cold_sync (
    .clk (clk), .arst_n (cold_rst_n), .srst_n (cfg_rst_n)
  );
  perst_rst_sync #(.STAGES(2)) u_warm_sync (
    .clk (clk), .arst_n (warm_arst_n), .srst_n (irq_rst_n)
  );

  assign irq_wr = reg_we && (reg_addr == ADDR_W'(NPORTS));

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign cfg_we[i] = reg_we && (reg_addr == ADDR_W'(i));

    perst_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk         (clk),
      .cfg_rst_n   (cfg_rst_n),
      .irq_rst_n   (irq_rst_n),
      .host_strap  (host_strap[i]),
      .perst_in_n  (perst_in_n[i]),
      .link_down   (link_down[i]),
      .hot_rst     (hot_rst[i]),
      .cfg_we      (cfg_we[i]),
      .cfg_wdata   (reg_wdata[CFG_W-1:0]),
      .perst_clr   (irq_wr & reg_wdata[i]),
      .link_clr    (irq_wr & reg_wdata[NPORTS+i]),
      .rd_word     (rd_words[i]),
      .perst_irq   (perst_irq[i]),
      .link_irq    (link_irq[i]),
      .warm_req    (warm_vec[i]),
      .perst_out_n (perst_out_n[i]),
      .perst_oe    (perst_oe[i]),
      .rst_done    (port_rst_done[i])
    );
  end

  always_comb warm_req_d = |warm_vec;

  always_ff @(posedge clk or negedge irq_rst_n) begin
    if (!irq_rst_n) chip_warm_req <= 1'b0;
    else            chip_warm_req <= warm_req_d;
  end

  assign irq = |{link_irq, perst_irq};

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata[RD_W-1:0] = rd_words[i];
    end
    if (reg_addr == ADDR_W'(NPORTS)) reg_rdata[IRQ_W-1:0] = {link_irq, perst_irq};
  end
endmodule

// File: tb/tb_perst_rst_ctrl.sv
module tb_perst_rst_ctrl;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          cold_rst_n, warm_rst_n;
  logic [N-1:0]  host_strap, perst_in_n, perst_out_n, perst_oe;
  logic [N-1:0]  link_down, hot_rst, port_rst_done;
  logic          reg_we, chip_warm_req, irq;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  perst_rst_ctrl dut (
    .clk (clk), .cold_rst_n (cold_rst_n), .warm_rst_n (warm_rst_n),
    .host_strap (host_strap), .perst_in_n (perst_in_n),
    .perst_out_n (perst_out_n), .perst_oe (perst_oe),
    .link_down (link_down), .hot_rst (hot_rst),
    .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .port_rst_done (port_rst_done),
    .chip_warm_req (chip_warm_req), .irq (irq)
  );

  typedef struct packed {
    logic [5:0] cfg;
    logic pin; logic pv; logic done; logic pirq; logic warm; logic oe; logic outn;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{6'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{6'h06, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{6'h02, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{6'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{6'h04, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{6'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{6'h21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{6'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic link_pulse(input int p, input bit use_hot, output logic warm_seen);
    @(negedge clk);
    if (use_hot) hot_rst[p] = 1'b1; else link_down[p] = 1'b1;
    @(negedge clk);
    warm_seen = chip_warm_req;
    hot_rst = '0; link_down = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    logic ws;
    cold_rst_n = 1'b0; warm_rst_n = 1'b1;
    host_strap = 4'b0101; perst_in_n = '1;
    link_down = '0; hot_rst = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 reset state from straps (R12 layout)
    rd(0, w); chk("R7 host cfg p0", w, 16'h0121);
    rd(1, w); chk("R7 endpoint cfg p1", w, 16'h008A);
    rd(2, w); chk("R7 host cfg p2", w, 16'h0121);
    rd(3, w); chk("R7 endpoint cfg p3", w, 16'h008A);
    rd(4, w); chk("R7 irq word", w, 16'h0000);
    chk("R8 reset oe", perst_oe, 4'b0101);
    chk("R8 reset out_n", perst_out_n, 4'b1010);
    chk("R4 reset done", port_rst_done, 4'b1010);
    chk("R7 reset warm", chip_warm_req, 1'b0);
    rd(7, w); chk("R12 unused address", w, 16'h0000);

    // table walk on port 0: R1 R2 R3 R4 R8 R10
    for (int k = 0; k < 8; k++) begin
      wr(0, {10'd0, VECS[k].cfg});
      perst_in_n[0] = ~VECS[k].pin;
      repeat (3) @(negedge clk);
      rd(0, w);
      chk("R10 pin readback", w[6], VECS[k].pv);
      chk("R4 done bit", w[7], VECS[k].done);
      chk("R4 done port", port_rst_done[0], VECS[k].done);
      rd(4, w);
      chk("R3 R1 perst irq", w, {15'd0, VECS[k].pirq});
      chk("R3 irq out", irq, VECS[k].pirq);
      chk("R2 R1 warm req", chip_warm_req, VECS[k].warm);
      chk("R8 oe", perst_oe[0], VECS[k].oe);
      chk("R8 out_n", perst_out_n[0], VECS[k].outn);
      perst_in_n[0] = 1'b1;
      repeat (3) @(negedge clk);
      wr(4, 16'h00FF);
    end
    wr(0, 16'h0000);

    // R11 synchronizer latency on port 3 (endpoint default)
    @(negedge clk);
    perst_in_n[3] = 1'b0;
    @(negedge clk);
    rd(3, w); chk("R11 one edge not seen", w[6], 1'b0);
    @(negedge clk);
    rd(3, w); chk("R11 two edges seen", w[6], 1'b1);
    rd(4, w); chk("R11 irq not yet", w[3], 1'b0);
    @(negedge clk);
    rd(4, w); chk("R11 irq third edge", w[3], 1'b1);
    perst_in_n[3] = 1'b1;
    repeat (3) @(negedge clk);
    wr(4, 16'h0008);
    rd(4, w); chk("R11 W1C perst", w, 16'h0000);

    // R5 endpoint default on port 1: warm request, no interrupt
    link_pulse(1, 1'b0, ws);
    chk("R5 warm on link", ws, 1'b1);
    @(negedge clk);
    chk("R5 warm one cycle", chip_warm_req, 1'b0);
    rd(4, w); chk("R5 no link irq", w, 16'h0000);

    // R5 R6 link-warm off, soft-on-link on
    wr(1, 16'h0012);
    link_pulse(1, 1'b1, ws);
    chk("R5 no warm when disabled", ws, 1'b0);
    rd(4, w); chk("R5 link irq set", w, 16'h0020);
    rd(1, w); chk("R6 soft set by event", w[5], 1'b1);
    chk("R4 done low after soft", port_rst_done[1], 1'b0);
    chk("R8 out_n follows soft", perst_out_n[1], 1'b0);

    // R11 write of 0 leaves a flag
    wr(4, 16'h0001);
    rd(4, w); chk("R11 W1C other bit", w, 16'h0020);

    // R9 warm reset keeps configuration, clears flags
    @(negedge clk);
    warm_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    warm_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(1, w); chk("R9 cfg kept", w[5:0], 6'h32);
    rd(4, w); chk("R9 irq cleared", w, 16'h0000);

    // R5 enabled but reset-done 0: neither warm nor interrupt
    wr(1, 16'h003A);
    link_pulse(1, 1'b0, ws);
    chk("R5 no warm when not done", ws, 1'b0);
    rd(4, w); chk("R5 no irq when enabled", w, 16'h0000);

    // R6 event set wins over same-cycle write of soft 0
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0012; link_down[1] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; link_down = '0;
    rd(1, w); chk("R6 set wins over write", w[5:0], 6'h32);

    // R7 cold reset restores defaults
    @(negedge clk);
    cold_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    cold_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(1, w); chk("R7 cold restores p1", w, 16'h008A);
    rd(0, w); chk("R7 cold restores p0", w, 16'h0121);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule